// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the state changes a 32-bit core makes when it accepts a trap or interrupt. The core presents a request with a cause code, an 8-bit vector, the current PC, the flag register, the stack pointer, the saved kernel stack pointer, the vector-table base and the pending delay-slot count. The sequencer captures these values and picks the vector and the return register. It forms the exception-status word, swaps stacks when the core was in user mode, and pushes the flag register one mode level up. It then reads the handler address from the vector table through a small read port.

All results are presented together during a one-cycle completion pulse. Each register update comes with its own write enable, so the core commits them in that cycle. The pulse also tells the core to clear its delay-slot counter and its pending-cause record. A request that arrives while an entry is in progress is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause code 1 (non-maskable) uses vector 0, writes the return register for that cause (`nrp_o` = captured PC, not reduced by the delay-slot count), does not write `erp_o`, and clears flag bit 30 before the flag shift.
- R2: Cause code 0 (break) uses `vec_i` as the vector and writes `erp_o` with the captured PC.
- R3: Cause codes 2 (bus fault) and 3 (external interrupt) use `vec_i` as the vector and write `erp_o` with the captured PC.
- R4: `exs_o` holds the 8-bit vector in bits 15:8 and zero in every other bit.
- R5: For causes other than 1, `erp_o` equals the PC minus `dslot_i`. `dslot_clr_o` and `cause_clr_o` pulse together with `done_o` for every entry.
- R6: When flag bit 8 (user mode) is set at entry, `usp_o` takes `sp_i`, `sp_o` takes `ksp_i`, and both write enables assert. When the bit is clear, neither enable asserts.
- R7: `ccs_o` = ((f & 0xC000_0000) | ((f << 12) >> 2)) & ~0x3FF, where f is the captured flag word (after the R1 clear). This leaves bit 8 clear.
- R8: The vector-table read presents address `ebp_i` + 4 × vector and holds the request and address stable until `mem_ready_i`.
- R9: `done_o` is a single-cycle pulse. In that cycle `pc_o` equals the word returned on `mem_rdata_i`, and all write enables are valid.
- R10: A request seen while `busy_o` is high is ignored. The entry in progress completes with its own inputs, and no second entry follows.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and all write enables are low.
- R12: Any number of cycles between request acceptance and `mem_rvalid_i` is tolerated, and `done_o` stays low until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an entry (taken only when idle) |
| cause_i | input | 2 | 0 break, 1 non-maskable, 2 bus fault, 3 interrupt |
| vec_i | input | 8 | Vector for causes 0, 2, 3 |
| pc_i | input | 32 | PC at entry |
| ccs_i | input | 32 | Flag register at entry |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Saved kernel stack pointer |
| ebp_i | input | 32 | Vector-table base |
| dslot_i | input | 2 | Pending delay-slot count |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Vector-table read request |
| mem_addr_o | output | 32 | Read address |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pc_o | output | 32 | Handler address |
| erp_o | output | 32 | Exception return address |
| erp_we_o | output | 1 | Write enable for erp_o |
| nrp_o | output | 32 | Non-maskable return address |
| nrp_we_o | output | 1 | Write enable for nrp_o |
| exs_o | output | 32 | Exception-status word |
| ccs_o | output | 32 | Shifted flag register |
| sp_o | output | 32 | New stack pointer |
| sp_we_o | output | 1 | Write enable for sp_o |
| usp_o | output | 32 | Saved user stack pointer |
| usp_we_o | output | 1 | Write enable for usp_o |
| dslot_clr_o | output | 1 | Clear the delay-slot counter |
| cause_clr_o | output | 1 | Clear the pending cause |

## Verification
Every captured value reaches the ports only in the single completion cycle. A wrong vector, return selection or flag shift therefore appears as a wrong value on that one pulse, about five cycles after the request plus the memory latency. A bad vector capture shows earlier, as a wrong `mem_addr_o` on the first request cycle. A state machine that skips or repeats a state shows as an early, missing or doubled `done_o`, or as a request that drops before `mem_ready_i`. The bench watches the read port and the pulse cycle by cycle to catch these.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_BRK  = 2'd0,
    CAUSE_NMI  = 2'd1,
    CAUSE_BUSF = 2'd2,
    CAUSE_IRQ  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_SHIFT, ST_FREQ, ST_FWAIT, ST_DONE
  } state_e;
endpackage

// File: rtl/exc_ret_sel.sv
module exc_ret_sel import exc_entry_pkg::*; #(
  parameter int XLEN = 32,
  parameter int VW   = 8,
  parameter int DSW  = 2
) (
  input  logic [1:0]      cause_i,
  input  logic [VW-1:0]   vec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [DSW-1:0]  dslot_i,
  output logic [VW-1:0]   vec_o,
  output logic [XLEN-1:0] ret_o,
  output logic            nmi_o
);
  always_comb begin
    nmi_o = (cause_e'(cause_i) == CAUSE_NMI);
    vec_o = nmi_o ? '0 : vec_i;
    // only the ERP path backs up over a pending delay slot
    ret_o = nmi_o ? pc_i : pc_i - XLEN'(dslot_i);
  end
endmodule

// File: rtl/exc_ccs_shift.sv
module exc_ccs_shift #(
  parameter int XLEN  = 32,
  parameter int GRP   = 10,
  parameter int KEEP  = 2,
  parameter int M_BIT = 30
) (
  input  logic [XLEN-1:0] ccs_i,
  input  logic            clr_m_i,
  output logic [XLEN-1:0] ccs_o
);
  logic [XLEN-1:0] src;

  always_comb begin
    src        = ccs_i;
    src[M_BIT] = ccs_i[M_BIT] & ~clr_m_i;
  end

  for (genvar k = 0; k < XLEN; k++) begin : g_bit
    if (k < GRP) begin : g_clr
      assign ccs_o[k] = 1'b0;
    end else if (k < XLEN - KEEP) begin : g_mov
      assign ccs_o[k] = src[k-GRP];
    end else begin : g_keep
      assign ccs_o[k] = src[k];
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq import exc_entry_pkg::*; #(
  parameter int XLEN  = 32,
  parameter int VW    = 8,
  parameter int DSW   = 2,
  parameter int U_BIT = 8,
  parameter int M_BIT = 30,
  parameter int GRP   = 10,
  parameter int KEEP  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      cause_i,
  input  logic [VW-1:0]   vec_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ccs_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] ksp_i,
  input  logic [XLEN-1:0] ebp_i,
  input  logic [DSW-1:0]  dslot_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_ready_i,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] erp_o,
  output logic            erp_we_o,
  output logic [XLEN-1:0] nrp_o,
  output logic            nrp_we_o,
  output logic [XLEN-1:0] exs_o,
  output logic [XLEN-1:0] ccs_o,
  output logic [XLEN-1:0] sp_o,
  output logic            sp_we_o,
  output logic [XLEN-1:0] usp_o,
  output logic            usp_we_o,
  output logic            dslot_clr_o,
  output logic            cause_clr_o
);
  localparam int EXS_LSB = 8;
  localparam int WSH     = 2; // word-sized table entries

  state_e          state_q, state_d;
  logic [VW-1:0]   sel_vec, vec_q;
  logic [XLEN-1:0] sel_ret, ret_q;
  logic            sel_nmi, nmi_q, user_q;
  logic [XLEN-1:0] ccs_q, ccs_sh, sp_in_q, ksp_q, ebp_q;
  logic [XLEN-1:0] pc_q, erp_q, nrp_q, exs_q, sp_q, usp_q;

  exc_ret_sel #(.XLEN(XLEN), .VW(VW), .DSW(DSW)) u_sel (
    .cause_i (cause_i),
    .vec_i   (vec_i),
    .pc_i    (pc_i),
    .dslot_i (dslot_i),
    .vec_o   (sel_vec),
    .ret_o   (sel_ret),
    .nmi_o   (sel_nmi)
  );

  exc_ccs_shift #(.XLEN(XLEN), .GRP(GRP), .KEEP(KEEP), .M_BIT(M_BIT)) u_shift (
    .ccs_i   (ccs_q),
    .clr_m_i (nmi_q),
    .ccs_o   (ccs_sh)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_SHIFT;
      ST_SHIFT: state_d = ST_FREQ;
      ST_FREQ:  if (mem_ready_i) state_d = ST_FWAIT;
      ST_FWAIT: if (mem_rvalid_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
      ret_q   <= '0;
      nmi_q   <= 1'b0;
      user_q  <= 1'b0;
      ccs_q   <= '0;
      sp_in_q <= '0;
      ksp_q   <= '0;
      ebp_q   <= '0;
      pc_q    <= '0;
      erp_q   <= '0;
      nrp_q   <= '0;
      exs_q   <= '0;
      sp_q    <= '0;
      usp_q   <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          vec_q   <= sel_vec;
          ret_q   <= sel_ret;
          nmi_q   <= sel_nmi;
          user_q  <= ccs_i[U_BIT];
          ccs_q   <= ccs_i;
          sp_in_q <= sp_i;
          ksp_q   <= ksp_i;
          ebp_q   <= ebp_i;
        end
        ST_SAVE: begin
          if (nmi_q) nrp_q <= ret_q;
          else       erp_q <= ret_q;
          exs_q <= XLEN'(vec_q) << EXS_LSB;
          if (user_q) begin
            usp_q <= sp_in_q;
            sp_q  <= ksp_q;
          end
        end
        ST_SHIFT: ccs_q <= ccs_sh;
        ST_FWAIT: if (mem_rvalid_i) pc_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_FREQ);
  assign mem_addr_o  = ebp_q + (XLEN'(vec_q) << WSH);
  assign pc_o        = pc_q;
  assign erp_o       = erp_q;
  assign nrp_o       = nrp_q;
  assign exs_o       = exs_q;
  assign ccs_o       = ccs_q;
  assign sp_o        = sp_q;
  assign usp_o       = usp_q;
  assign erp_we_o    = done_o & ~nmi_q;
  assign nrp_we_o    = done_o & nmi_q;
  assign sp_we_o     = done_o & user_q;
  assign usp_we_o    = done_o & user_q;
  assign dslot_clr_o = done_o;
  assign cause_clr_o = done_o;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int VW   = 8,
  parameter int GRP  = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_ready_i,
  input logic [XLEN-1:0] exs_o,
  input logic [XLEN-1:0] ccs_o,
  input logic            erp_we_o,
  input logic            nrp_we_o,
  input logic            sp_we_o,
  input logic            usp_we_o,
  input logic            dslot_clr_o,
  input logic            cause_clr_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_EXS_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> exs_o[7:0] == '0 && (exs_o >> (8 + VW)) == '0); // R4
  AST_CCS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ccs_o[GRP-1:0] == '0); // R7
  AST_NMI_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrp_we_o |-> exs_o[15:8] == '0 && !erp_we_o); // R1
  AST_STACK_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> usp_we_o && done_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o); // R10
  AST_CLR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_clr_o |-> done_o && dslot_clr_o); // R5
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .VW(VW), .GRP(GRP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .exs_o       (exs_o),
  .ccs_o       (ccs_o),
  .erp_we_o    (erp_we_o),
  .nrp_we_o    (nrp_we_o),
  .sp_we_o     (sp_we_o),
  .usp_we_o    (usp_we_o),
  .dslot_clr_o (dslot_clr_o),
  .cause_clr_o (cause_clr_o)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  cause_i = '0;
  logic [7:0]  vec_i = '0;
  logic [31:0] pc_i = '0, ccs_i = '0, sp_i = '0, ksp_i = '0, ebp_i = '0;
  logic [1:0]  dslot_i = '0;
  logic        busy_o, done_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] pc_o, erp_o, nrp_o, exs_o, ccs_o, sp_o, usp_o;
  logic        erp_we_o, nrp_we_o, sp_we_o, usp_we_o, dslot_clr_o, cause_clr_o;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_seq dut (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] shift_ref(logic [31:0] c);
    return ((c & 32'hC000_0000) | ((c << 12) >> 2)) & ~32'h3FF;
  endfunction

  task automatic run_entry(logic [1:0] cause, logic [7:0] vec, logic [31:0] pc, ccs,
                           sp, ksp, ebp, logic [1:0] ds, int rdly, int wdly,
                           logic [31:0] hdl, bit inject);
    bit          nmi  = (cause == 2'd1);
    logic [7:0]  ev   = nmi ? 8'd0 : vec;
    bit          user = ccs[8];
    logic [31:0] cm   = nmi ? (ccs & ~32'h4000_0000) : ccs;
    logic [31:0] addr = ebp + {22'd0, ev, 2'b00};
    int          n    = 0;
    @(negedge clk_i);
    req_i = 1; cause_i = cause; vec_i = vec; pc_i = pc; ccs_i = ccs;
    sp_i = sp; ksp_i = ksp; ebp_i = ebp; dslot_i = ds;
    @(negedge clk_i);
    req_i = 0;
    if (inject) begin  // R10: new request while busy
      req_i = 1; cause_i = ~cause; vec_i = ~vec; pc_i = ~pc; ccs_i = ~ccs;
      sp_i = ~sp; ksp_i = ~ksp; ebp_i = ~ebp; dslot_i = ~ds;
      chk("R10 busy", {31'd0, busy_o}, 32'd1);
      @(negedge clk_i);
      req_i = 0;
    end
    while (!mem_req_o && n < 20) begin @(negedge clk_i); n++; end
    chk("R8 req", {31'd0, mem_req_o}, 32'd1);
    chk("R8 addr", mem_addr_o, addr);
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk_i);
      chk("R8 hold", {31'd0, mem_req_o}, 32'd1);
      chk("R8 stable", mem_addr_o, addr);
    end
    mem_ready_i = 1;
    @(negedge clk_i);
    mem_ready_i = 0;
    chk("R8 req drop", {31'd0, mem_req_o}, 32'd0);
    for (int i = 0; i < wdly; i++) begin
      chk("R12 wait", {31'd0, done_o}, 32'd0);
      @(negedge clk_i);
    end
    mem_rvalid_i = 1; mem_rdata_i = hdl;
    @(negedge clk_i);
    mem_rvalid_i = 0; mem_rdata_i = '0;
    chk("R9 done", {31'd0, done_o}, 32'd1);
    chk("R9 pc", pc_o, hdl);
    chk("R4 exs", exs_o, {16'd0, ev, 8'd0});
    chk("R7 ccs", ccs_o, shift_ref(cm));
    chk("R5 clr", {30'd0, dslot_clr_o, cause_clr_o}, 32'd3);
    if (nmi) begin
      chk("R1 we", {30'd0, nrp_we_o, erp_we_o}, 32'd2);
      chk("R1 nrp", nrp_o, pc);
    end else begin
      chk("R2 R3 we", {30'd0, nrp_we_o, erp_we_o}, 32'd1);
      chk("R5 erp", erp_o, pc - {30'd0, ds});
    end
    chk("R6 we", {30'd0, sp_we_o, usp_we_o}, user ? 32'd3 : 32'd0);
    if (user) begin
      chk("R6 sp", sp_o, ksp);
      chk("R6 usp", usp_o, sp);
    end
    @(negedge clk_i);
    chk("R9 pulse", {31'd0, done_o}, 32'd0);
    chk("R10 idle", {30'd0, busy_o, mem_req_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 busy", {31'd0, busy_o}, 32'd0);
    chk("R11 done", {31'd0, done_o}, 32'd0);
    chk("R11 req", {31'd0, mem_req_o}, 32'd0);
    chk("R11 we", {28'd0, erp_we_o, nrp_we_o, sp_we_o, usp_we_o}, 32'd0);
  endtask

  initial begin
    #12 rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    // R2 break, user mode
    run_entry(2'd0, 8'h21, 32'h0000_1000, 32'h4000_0153, 32'h7000_0000,
              32'h8000_F000, 32'h0000_2000, 2'd0, 0, 0, 32'hC000_0100, 0);
    // R1 NMI, M set, delay slot must not touch NRP
    run_entry(2'd1, 8'h5A, 32'h0000_3004, 32'hC00F_F0FF & ~32'h100, 32'h1,
              32'h2, 32'h0001_0000, 2'd2, 1, 2, 32'hC000_0200, 0);
    // R3 bus fault, delay slot, user, long latency
    run_entry(2'd2, 8'h0E, 32'h0000_4008, 32'h0000_0100, 32'h7FFF_FF00,
              32'h8000_0000, 32'h0000_8000, 2'd1, 3, 4, 32'hC000_0300, 0);
    // R3 interrupt, top vector
    run_entry(2'd3, 8'hFF, 32'hFFFF_FFFC, 32'hFFFF_FEFF, 32'h11,
              32'h22, 32'hFFFF_F000, 2'd3, 0, 1, 32'hC000_0400, 0);
    // R10 request while busy is dropped
    run_entry(2'd3, 8'h33, 32'h0000_5000, 32'h8000_0000, 32'h44,
              32'h55, 32'h0000_0400, 2'd0, 2, 0, 32'hC000_0500, 1);
    repeat (3) @(negedge clk_i);
    chk("R10 no second", {30'd0, busy_o, done_o}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule